// File: doc/BRIEF.md
# Peripheral Security Attribute Register

This block is one memory-mapped configuration word that marks each of a small set of peripherals as secure or non-secure. Each implemented flag drives a per-peripheral secure output that downstream access filters use. A write is honoured bit by bit only when the transaction's security and privilege attributes, that bit's privilege setting, the global lock and the system security enable all permit it.

The register answers on a simple single-cycle register port. A write takes effect at the clock edge on which it is presented. Read data is registered and appears one cycle after the address. The privilege-configuration vector, lock and security enable come from neighbouring logic as plain levels. An illegal-access pulse reports refused writes of the kinds listed below. No handshake is used at the port: every access completes in its own cycle and there is no back-pressure.

Top module: `psar_top`

## Requirements
- R1: After reset every stored flag is 0, so a read at byte offset 0x010 returns 0x0000_0000 and `periph_secure` is 0.
- R2: Only bit positions 13, 3 and 2 are implemented (mask 0x0000_200C). Writes to all other positions are ignored, and those positions always read as 0.
- R3: A write with `bus_secure`=0 changes no stored bit.
- R4: A bit whose `priv_cfg` bit is 1 is updated only by a write that has both `bus_secure`=1 and `bus_priv`=1.
- R5: A bit whose `priv_cfg` bit is 0 is updated by any secure write, whether privileged or not.
- R6: Permission is decided per bit. A secure write updates exactly the bits it may change and leaves the others as they were.
- R7: A read is allowed for any combination of `bus_secure` and `bus_priv`. Its data appears on `bus_rdata` one cycle after the address is presented. An address other than 0x010 reads as 0.
- R8: Once `lock_in` is seen as 1, no write changes the register until the next reset, even after `lock_in` returns to 0.
- R9: While `sec_en` is 0, writes are ignored, reads return 0 and `periph_secure` is 0. The stored contents reappear when `sec_en` returns to 1.
- R10: `illegal_pulse` goes high for one cycle, in the cycle after a write to 0x010 made while `sec_en`=1, when that write is either non-secure, or secure and unprivileged while all three implemented `priv_cfg` bits are 1. It stays low otherwise, including for every write made while `sec_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | 1 = write in this cycle |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Transaction is secure |
| bus_priv | input | 1 | Transaction is privileged |
| bus_rdata | output | 32 | Registered read data |
| priv_cfg | input | 32 | Per-bit privilege configuration from the companion register |
| lock_in | input | 1 | Global configuration lock |
| sec_en | input | 1 | System security enable |
| periph_secure | output | 32 | Per-peripheral secure flags (reserved positions 0) |
| illegal_pulse | output | 1 | One-cycle illegal-access event |

## Verification
Writes are tried with every mix of secure and privileged attributes against a privilege vector that is all clear, partly set and fully set. This separates the per-bit privilege gate from the whole-word security gate, and a partly permitted write shows that only the permitted bits move. Writes of all ones show that the reserved positions stay at 0. Reads are made with non-secure attributes and at a wrong address. A brief lock pulse followed by a write shows that the lock is sticky, and a later reset shows that it clears. Toggling the security enable shows that reads are masked while the stored state is kept, and that no event is raised in that mode.

// File: rtl/psar_pkg.sv
package psar_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 12;
  localparam logic [DATA_W-1:0] IMPL_MASK_DEF = 32'h0000_200C;
  localparam logic [ADDR_W-1:0] REG_OFFSET_DEF = 12'h010;

  typedef enum logic [1:0] {
    ATTR_NS_UNPRIV = 2'b00,
    ATTR_NS_PRIV   = 2'b01,
    ATTR_S_UNPRIV  = 2'b10,
    ATTR_S_PRIV    = 2'b11
  } attr_e;

  function automatic logic covers_all(input logic [DATA_W-1:0] cfg,
                                      input logic [DATA_W-1:0] mask);
    return (cfg & mask) == mask;
  endfunction
endpackage

// File: rtl/psar_access.sv
module psar_access
  import psar_pkg::*;
#(
  parameter logic [DATA_W-1:0] IMPL_MASK = IMPL_MASK_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_wr,
  input  attr_e             attr,
  input  logic [DATA_W-1:0] priv_cfg,
  input  logic              lock_in,
  input  logic              sec_en,
  output logic [DATA_W-1:0] wr_allow,
  output logic              lock_seen,
  output logic              illegal_pulse
);
  logic is_secure, is_priv, blocked, all_priv, ill_d;

  assign is_secure = attr[1];
  assign is_priv   = attr[0];
  assign blocked   = lock_in | lock_seen;
  assign all_priv  = covers_all(priv_cfg, IMPL_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_seen <= 1'b0;
    else if (lock_in) lock_seen <= 1'b1;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_gate
    if (IMPL_MASK[i]) begin : g_impl
      assign wr_allow[i] = hit_wr & sec_en & ~blocked & is_secure
                           & (is_priv | ~priv_cfg[i]);
    end else begin : g_rsv
      assign wr_allow[i] = 1'b0;
    end
  end

  assign ill_d = hit_wr & sec_en & (~is_secure | (~is_priv & all_priv));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_pulse <= 1'b0;
    else        illegal_pulse <= ill_d;
  end

  AST_SP_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr && attr == ATTR_S_PRIV) |=> !illegal_pulse); // R10
  AST_EVENT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_pulse |-> $past(hit_wr && sec_en)); // R10
endmodule

// File: rtl/psar_store.sv
module psar_store
  import psar_pkg::*;
#(
  parameter logic [DATA_W-1:0] IMPL_MASK = IMPL_MASK_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_allow,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_cell
    if (IMPL_MASK[i]) begin : g_ff
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           q[i] <= 1'b0;
        else if (wr_allow[i]) q[i] <= wdata[i];
      end
    end else begin : g_zero
      assign q[i] = 1'b0;
    end
  end

  AST_NO_ALLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_allow == '0) |=> $stable(q)); // R6
endmodule

// File: rtl/psar_rdport.sv
module psar_rdport
  import psar_pkg::*;
#(
  parameter logic [ADDR_W-1:0] REG_OFFSET = REG_OFFSET_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sec_en,
  input  logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             rdata <= '0;
    else if (addr == REG_OFFSET && sec_en)  rdata <= q;
    else                                    rdata <= '0;
  end

  AST_RD_SECDIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_en |=> (rdata == '0)); // R9
  AST_RD_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != REG_OFFSET) |=> (rdata == '0)); // R7
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == REG_OFFSET && sec_en) |=> (rdata == $past(q))); // R7
endmodule

// File: rtl/psar_top.sv
module psar_top
  import psar_pkg::*;
#(
  parameter logic [DATA_W-1:0] IMPL_MASK  = IMPL_MASK_DEF,
  parameter logic [ADDR_W-1:0] REG_OFFSET = REG_OFFSET_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_secure,
  input  logic              bus_priv,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] priv_cfg,
  input  logic              lock_in,
  input  logic              sec_en,
  output logic [DATA_W-1:0] periph_secure,
  output logic              illegal_pulse
);
  logic              hit_wr, lock_seen;
  logic [DATA_W-1:0] wr_allow, q;
  attr_e             attr;

  assign hit_wr = bus_wr && (bus_addr == REG_OFFSET);
  assign attr   = attr_e'({bus_secure, bus_priv});

  psar_access #(.IMPL_MASK(IMPL_MASK)) u_access (
    .clk(clk), .rst_n(rst_n), .hit_wr(hit_wr), .attr(attr),
    .priv_cfg(priv_cfg), .lock_in(lock_in), .sec_en(sec_en),
    .wr_allow(wr_allow), .lock_seen(lock_seen), .illegal_pulse(illegal_pulse)
  );

  psar_store #(.IMPL_MASK(IMPL_MASK)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_allow(wr_allow), .wdata(bus_wdata), .q(q)
  );

  psar_rdport #(.REG_OFFSET(REG_OFFSET)) u_rd (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .sec_en(sec_en),
    .q(q), .rdata(bus_rdata)
  );

  assign periph_secure = sec_en ? q : '0;

  AST_NS_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr && !bus_secure) |=> $stable(q)); // R3
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lock_seen |=> $stable(q)); // R8
  AST_SECDIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_en |=> $stable(q)); // R9
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hit_wr |=> ((q & ~IMPL_MASK) == '0)); // R2
  AST_PRIV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_wr && !bus_priv) |=> (((q ^ $past(q)) & $past(priv_cfg)) == '0)); // R4
endmodule

// File: tb/tb_psar_top.sv
module tb_psar_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] OFF = 12'h010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_secure = 1'b0, bus_priv = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] priv_cfg = '0;
  logic        lock_in = 1'b0, sec_en = 1'b1;
  logic [31:0] periph_secure;
  logic        illegal_pulse;

  int n_tests = 0, n_fail = 0;
  logic issue = 1'b0, issue_cap = 1'b0;
  logic [31:0] exp_rd_q[$];
  logic        chk_rd_q[$];
  logic        exp_ill_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  psar_top dut (.*);

  always @(posedge clk) issue_cap <= issue;

  // monitor: pops expected items one cycle after the driver issued them
  always @(negedge clk) begin
    if (issue_cap && exp_rd_q.size() > 0) begin
      logic [31:0] er; logic cr; logic ei; string t;
      er = exp_rd_q.pop_front(); cr = chk_rd_q.pop_front();
      ei = exp_ill_q.pop_front(); t = tag_q.pop_front();
      if (cr) begin
        n_tests++;
        if (bus_rdata !== er) begin
          n_fail++;
          $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata, er);
        end
      end
      n_tests++;
      if (illegal_pulse !== ei) begin
        n_fail++;
        $display("FAIL %s illegal_pulse actual=%b expected=%b", t, illegal_pulse, ei);
      end
    end
  end

  task automatic op(input logic wr, input logic [11:0] a, input logic [31:0] d,
                    input logic s, input logic p, input logic chk_rd,
                    input logic [31:0] exp_rd, input logic exp_ill, input string t);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d; bus_secure = s; bus_priv = p;
    issue = 1'b1;
    exp_rd_q.push_back(exp_rd); chk_rd_q.push_back(chk_rd);
    exp_ill_q.push_back(exp_ill); tag_q.push_back(t);
  endtask

  task automatic rd(input logic s, input logic p, input logic [31:0] e, input string t);
    op(1'b0, OFF, 32'h0, s, p, 1'b1, e, 1'b0, t);
  endtask

  task automatic wr(input logic [31:0] d, input logic s, input logic p,
                    input logic ei, input string t);
    op(1'b1, OFF, d, s, p, 1'b0, 32'h0, ei, t);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 12'h0; issue = 1'b0;
  endtask

  task automatic chk_periph(input logic [31:0] e, input string t);
    idle();
    n_tests++;
    if (periph_secure !== e) begin
      n_fail++;
      $display("FAIL %s periph_secure actual=%h expected=%h", t, periph_secure, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(1'b1, 1'b1, 32'h0, "R1 reset read");
    chk_periph(32'h0, "R1 reset periph");
    wr(32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, "R5 secure unpriv write");
    rd(1'b1, 1'b0, 32'h0000_200C, "R2 R5 reserved masked");
    wr(32'h0, 1'b0, 1'b1, 1'b1, "R3 R10 non-secure write event");
    rd(1'b0, 1'b1, 32'h0000_200C, "R3 unchanged");
    rd(1'b0, 1'b0, 32'h0000_200C, "R7 non-secure read");
    op(1'b0, 12'h014, 32'h0, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, "R7 other address");
    priv_cfg = 32'h0000_0004;
    wr(32'h0, 1'b1, 1'b0, 1'b0, "R6 partial write, no event");
    rd(1'b1, 1'b1, 32'h0000_0004, "R4 R6 partial result");
    wr(32'h0000_2008, 1'b1, 1'b1, 1'b0, "R4 privileged write");
    rd(1'b1, 1'b1, 32'h0000_2008, "R4 privileged result");
    priv_cfg = 32'h0000_200C;
    wr(32'h0, 1'b1, 1'b0, 1'b1, "R10 all-privileged unpriv event");
    rd(1'b1, 1'b1, 32'h0000_2008, "R4 all privileged hold");
    wr(32'h0000_000C, 1'b1, 1'b1, 1'b0, "R4 priv write");
    rd(1'b1, 1'b1, 32'h0000_000C, "R4 priv write result");
    chk_periph(32'h0000_000C, "R2 periph flags");
    sec_en = 1'b0;
    rd(1'b1, 1'b1, 32'h0, "R9 read zero when disabled");
    chk_periph(32'h0, "R9 periph zero when disabled");
    wr(32'h0000_2000, 1'b1, 1'b1, 1'b0, "R9 write ignored");
    wr(32'h0, 1'b0, 1'b0, 1'b0, "R10 no event when disabled");
    idle();
    sec_en = 1'b1;
    rd(1'b1, 1'b1, 32'h0000_000C, "R9 contents kept");
    priv_cfg = 32'h0;
    idle();
    lock_in = 1'b1;
    idle();
    lock_in = 1'b0;
    wr(32'h0000_2000, 1'b1, 1'b1, 1'b0, "R8 write after lock");
    rd(1'b1, 1'b1, 32'h0000_000C, "R8 sticky lock");
    idle(); idle();
    rst_n = 1'b0;
    idle();
    rst_n = 1'b1;
    rd(1'b1, 1'b1, 32'h0, "R1 reset again");
    wr(32'h0000_2000, 1'b1, 1'b1, 1'b0, "R8 lock cleared by reset");
    rd(1'b1, 1'b1, 32'h0000_2000, "R8 write after reset");
    idle(); idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule